// File: doc/BRIEF.md
# Interrupt Controller Setup Register Front End

This block is the programmable side of a legacy-style eight-input interrupt controller. A byte-wide write/read bus with one address bit reaches it through two chip-selects. One select covers the controller's command port (address bit 0 low) and data port (address bit 0 high). The other covers a companion trigger-mode register. A write to the command port with data bit 4 set starts a setup sequence. The data-port writes that follow are taken in a fixed order: vector base, then cascade word, then mode word. A flag in the first word decides whether the cascade word is expected, and another decides whether the mode word is expected. Once the sequence is complete, data-port writes set the interrupt mask.

The block holds the resulting configuration and drives it out as plain outputs: mask, vector base, cascade word, mode word, lowest-priority input and special-mask flag. It also composes the vector for a given input number. Two simple command-port operations change the priority and special-mask state once setup is complete. The trigger-mode register sets one bit per interrupt line, with 1 meaning level-triggered and 0 meaning edge-triggered. It is split into bytes that each have their own address. Priority resolution, acknowledge cycles and vector delivery belong to neighbouring logic.

Top module: `pic_init_regs`

## Requirements
- R1: After reset the block is uninitialized (`init_done`=0), the mask is 0xFF, and the trigger bits, vector base, cascade word and mode word are all zero. `lowest_prio` is 7 and `special_mask` is 0.
- R2: A command-port write (address 0) with data bit 4 set does the following: it clears the mask, cascade word and mode word, sets `lowest_prio` to 7, clears `special_mask`, drops `init_done`, and restarts the sequence. This holds even in the middle of an earlier sequence. Its bit 0 set means a mode word will follow. Its bit 1 set means single mode, with no cascade word.
- R3: The first data-port write after the start word stores data bits 7:3 as the vector base. `vec_out` equals {vector base, `vec_sel`}.
- R4: In cascade mode the next data write is the cascade word. The mode word follows only when it was flagged. `init_done` rises with the last expected word.
- R5: In single mode the cascade word is skipped and stays 0. The next data write after the vector base is either the mode word (if flagged) or completes setup.
- R6: Data-port writes during a sequence leave the mask unchanged. Data-port writes when no sequence is pending, whether before any setup or after it completes, load the mask (1 = masked).
- R7: A read of the data port returns the mask. A read of the command port returns 0x00. `bus_rdata` is 0x00 whenever `bus_rd` is low.
- R8: Trigger register: address 0 holds the bits for lines 0–7 and address 1 holds the bits for lines 8–15. Each byte reads back exactly what was written. Writes to it do not affect the controller.
- R9: Special-mask command: a command-port write with bit 4 = 0 and bit 3 = 1, accepted only after setup. Bits 6:5 = 11 set `special_mask`, 10 clears it, and any other value leaves it unchanged.
- R10: Priority command: a command-port write with bits 4:3 = 00 and bits 7:5 = 110, accepted only after setup, loads `lowest_prio` from bits 2:0. Other codes with bits 4:3 = 00 have no effect.
- R11: A write with neither chip-select asserted changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_pic | input | 1 | Select for the controller command/data ports |
| bus_cs_trig | input | 1 | Select for the trigger-mode register bytes |
| bus_addr | input | 1 | Address bit: port or byte select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| vec_sel | input | 3 | Input number for vector composition |
| vec_out | output | 8 | Composed vector |
| irq_mask | output | 8 | Interrupt mask, 1 = masked |
| vec_base | output | 5 | Stored vector base bits 7:3 |
| cascade_cfg | output | 8 | Cascade word |
| mode_word | output | 8 | Mode word |
| init_done | output | 1 | Setup sequence complete |
| special_mask | output | 1 | Special-mask flag |
| lowest_prio | output | 3 | Input with lowest priority |
| trig_level | output | 16 | Per-line trigger mode, 1 = level |

## Verification
The hardest state to reach is a start word that lands while an earlier sequence is still waiting for its later words. There the stale step must not capture the next data byte as the wrong word. The stimulus table issues a start word, feeds only the vector base, and then issues a second start word with different flags. The expected fields after each following write show whether the new sequence began cleanly. The commands that are accepted only after setup are also sent in the middle of a sequence, and their effect is observed on the flag outputs.

// File: rtl/picinit_pkg.sv
package picinit_pkg;

    localparam int BYTE_W  = 8;
    localparam int VBASE_W = 5;
    localparam int PRIO_W  = BYTE_W - VBASE_W;

    typedef enum logic [2:0] {
        ST_RAW,
        ST_VEC,
        ST_CAS,
        ST_MODE,
        ST_READY
    } seq_st_e;

    typedef struct packed {
        seq_st_e              st;
        logic                 need_mode;
        logic                 single;
        logic [VBASE_W-1:0]   vbase;
        logic [BYTE_W-1:0]    cas;
        logic [BYTE_W-1:0]    mode;
        logic [BYTE_W-1:0]    mask;
        logic [PRIO_W-1:0]    low_prio;
        logic                 smm;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RST = '{
        st:        ST_RAW,
        need_mode: 1'b0,
        single:    1'b0,
        vbase:     '0,
        cas:       '0,
        mode:      '0,
        mask:      '1,
        low_prio:  '1,
        smm:       1'b0
    };

    // command-port bit positions decoded by the sequencer
    localparam int BIT_START  = 4;
    localparam int BIT_SMMCMD = 3;
    localparam int BIT_NEED4  = 0;
    localparam int BIT_SINGLE = 1;

endpackage

// File: rtl/picinit_seq.sv
module picinit_seq
    import picinit_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs,
    input  logic                wr,
    input  logic                port_sel,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   mask,
    output logic [VBASE_W-1:0]  vbase,
    output logic [BYTE_W-1:0]   cas,
    output logic [BYTE_W-1:0]   mode,
    output logic [PRIO_W-1:0]   low_prio,
    output logic                smm,
    output logic                ready,
    output logic                busy
);

    seq_regs_t regs_d, regs_q;

    logic cmd_wr, dat_wr, start_wr, smm_cmd, prio_cmd;

    always_comb begin
        cmd_wr   = cs && wr && !port_sel;
        dat_wr   = cs && wr && port_sel;
        start_wr = cmd_wr && wdata[BIT_START];
        smm_cmd  = cmd_wr && !wdata[BIT_START] && wdata[BIT_SMMCMD]
                   && (regs_q.st == ST_READY);
        prio_cmd = cmd_wr && !wdata[BIT_START] && !wdata[BIT_SMMCMD]
                   && (regs_q.st == ST_READY) && (wdata[7:5] == 3'b110);
    end

    always_comb begin
        regs_d = regs_q;
        if (start_wr) begin
            regs_d.st        = ST_VEC;
            regs_d.need_mode = wdata[BIT_NEED4];
            regs_d.single    = wdata[BIT_SINGLE];
            regs_d.mask      = '0;
            regs_d.cas       = '0;
            regs_d.mode      = '0;
            regs_d.low_prio  = '1;
            regs_d.smm       = 1'b0;
        end else if (dat_wr) begin
            unique case (regs_q.st)
                ST_VEC: begin
                    regs_d.vbase = wdata[BYTE_W-1:PRIO_W];
                    if (!regs_q.single)        regs_d.st = ST_CAS;
                    else if (regs_q.need_mode) regs_d.st = ST_MODE;
                    else                       regs_d.st = ST_READY;
                end
                ST_CAS: begin
                    regs_d.cas = wdata;
                    regs_d.st  = regs_q.need_mode ? ST_MODE : ST_READY;
                end
                ST_MODE: begin
                    regs_d.mode = wdata;
                    regs_d.st   = ST_READY;
                end
                default: regs_d.mask = wdata;
            endcase
        end else if (smm_cmd) begin
            if (wdata[6:5] == 2'b11)      regs_d.smm = 1'b1;
            else if (wdata[6:5] == 2'b10) regs_d.smm = 1'b0;
        end else if (prio_cmd) begin
            regs_d.low_prio = wdata[PRIO_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= SEQ_RST;
        else        regs_q <= regs_d;
    end

    assign mask     = regs_q.mask;
    assign vbase    = regs_q.vbase;
    assign cas      = regs_q.cas;
    assign mode     = regs_q.mode;
    assign low_prio = regs_q.low_prio;
    assign smm      = regs_q.smm;
    assign ready    = (regs_q.st == ST_READY);
    assign busy     = (regs_q.st == ST_VEC) || (regs_q.st == ST_CAS)
                      || (regs_q.st == ST_MODE);

endmodule

// File: rtl/picinit_trig.sv
module picinit_trig
    import picinit_pkg::*;
#(
    parameter int ADDR_W = 1,
    localparam int NBYTES = 2 ** ADDR_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs,
    input  logic                         wr,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [BYTE_W-1:0]            wdata,
    output logic [NBYTES-1:0][BYTE_W-1:0] bytes_q
);

    logic [NBYTES-1:0][BYTE_W-1:0] bytes_d;
    logic [NBYTES-1:0]             byte_we;

    for (genvar g = 0; g < NBYTES; g++) begin : g_we
        assign byte_we[g] = cs && wr && (addr == ADDR_W'(g));
    end

    always_comb begin
        bytes_d = bytes_q;
        for (int i = 0; i < NBYTES; i++) begin
            if (byte_we[i]) bytes_d[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bytes_q <= '0;
        else        bytes_q <= bytes_d;
    end

endmodule

// File: rtl/picinit_rdmux.sv
module picinit_rdmux
    import picinit_pkg::*;
#(
    parameter int ADDR_W = 1,
    localparam int NBYTES = 2 ** ADDR_W
) (
    input  logic                          rd,
    input  logic                          cs_pic,
    input  logic                          cs_trig,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [BYTE_W-1:0]             mask,
    input  logic [NBYTES-1:0][BYTE_W-1:0] trig,
    output logic [BYTE_W-1:0]             rdata
);

    always_comb begin
        rdata = '0;
        if (rd && cs_pic) begin
            if (addr[0]) rdata = mask;
        end else if (rd && cs_trig) begin
            rdata = trig[addr];
        end
    end

endmodule

// File: rtl/pic_init_regs.sv
module pic_init_regs
    import picinit_pkg::*;
#(
    parameter int ADDR_W = 1,
    localparam int NBYTES = 2 ** ADDR_W,
    localparam int TRIG_W = NBYTES * BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_cs_pic,
    input  logic                bus_cs_trig,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic [PRIO_W-1:0]   vec_sel,
    output logic [BYTE_W-1:0]   vec_out,
    output logic [BYTE_W-1:0]   irq_mask,
    output logic [VBASE_W-1:0]  vec_base,
    output logic [BYTE_W-1:0]   cascade_cfg,
    output logic [BYTE_W-1:0]   mode_word,
    output logic                init_done,
    output logic                special_mask,
    output logic [PRIO_W-1:0]   lowest_prio,
    output logic [TRIG_W-1:0]   trig_level
);

    logic                          seq_busy;
    logic [NBYTES-1:0][BYTE_W-1:0] trig_bytes;

    picinit_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (bus_cs_pic),
        .wr       (bus_wr),
        .port_sel (bus_addr[0]),
        .wdata    (bus_wdata),
        .mask     (irq_mask),
        .vbase    (vec_base),
        .cas      (cascade_cfg),
        .mode     (mode_word),
        .low_prio (lowest_prio),
        .smm      (special_mask),
        .ready    (init_done),
        .busy     (seq_busy)
    );

    picinit_trig #(.ADDR_W(ADDR_W)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (bus_cs_trig),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .bytes_q (trig_bytes)
    );

    picinit_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
        .rd      (bus_rd),
        .cs_pic  (bus_cs_pic),
        .cs_trig (bus_cs_trig),
        .addr    (bus_addr),
        .mask    (irq_mask),
        .trig    (trig_bytes),
        .rdata   (bus_rdata)
    );

    assign trig_level = trig_bytes;
    assign vec_out    = {vec_base, vec_sel};

endmodule

// File: rtl/picinit_checker.sv
module picinit_checker
    import picinit_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                bus_cs_pic,
    input logic                bus_cs_trig,
    input logic                bus_addr0,
    input logic                bus_wr,
    input logic [BYTE_W-1:0]   bus_wdata,
    input logic [BYTE_W-1:0]   irq_mask,
    input logic [VBASE_W-1:0]  vec_base,
    input logic                init_done,
    input logic                special_mask,
    input logic [PRIO_W-1:0]   lowest_prio,
    input logic [15:0]         trig_level,
    input logic                seq_busy
);

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs_pic && bus_wr && !bus_addr0 && bus_wdata[BIT_START])
        |=> (irq_mask == '0) && !init_done && (lowest_prio == '1) && !special_mask); // R2

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs_pic && bus_wr && bus_addr0 && !seq_busy)
        |=> irq_mask == $past(bus_wdata)); // R6

    AST_MASK_HOLD_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs_pic && bus_wr && bus_addr0 && seq_busy)
        |=> $stable(irq_mask)); // R6

    AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs_trig && bus_wr) |=> $stable(trig_level)); // R8

    AST_VBASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs_pic && bus_wr && bus_addr0) |=> $stable(vec_base)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(irq_mask) && $stable(special_mask) && $stable(lowest_prio)); // R11

endmodule

bind pic_init_regs picinit_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_cs_pic   (bus_cs_pic),
    .bus_cs_trig  (bus_cs_trig),
    .bus_addr0    (bus_addr[0]),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .irq_mask     (irq_mask),
    .vec_base     (vec_base),
    .init_done    (init_done),
    .special_mask (special_mask),
    .lowest_prio  (lowest_prio),
    .trig_level   (trig_level),
    .seq_busy     (seq_busy)
);

// File: tb/pic_init_regs_test.sv
module pic_init_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_pic = 1'b0, bus_cs_trig = 1'b0;
    logic [0:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [2:0]  vec_sel = '0;
    logic [7:0]  vec_out, irq_mask, cascade_cfg, mode_word;
    logic [4:0]  vec_base;
    logic        init_done, special_mask;
    logic [2:0]  lowest_prio;
    logic [15:0] trig_level;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_init_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_cs_pic(bus_cs_pic), .bus_cs_trig(bus_cs_trig),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .vec_sel(vec_sel), .vec_out(vec_out), .irq_mask(irq_mask),
        .vec_base(vec_base), .cascade_cfg(cascade_cfg), .mode_word(mode_word),
        .init_done(init_done), .special_mask(special_mask), .lowest_prio(lowest_prio),
        .trig_level(trig_level)
    );

    typedef struct packed {
        logic       addr;
        logic [7:0] data;
        logic [7:0] mask;
        logic [4:0] vbase;
        logic [7:0] cas;
        logic [7:0] mode;
        logic       done;
    } step_t;

    localparam int NSTEP = 20;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b1, 8'h5A, 8'h5A, 5'h00, 8'h00, 8'h00, 1'b0},  // R6 mask before setup
        '{1'b0, 8'h11, 8'h00, 5'h00, 8'h00, 8'h00, 1'b0},  // R2 start, cascade, mode flagged
        '{1'b1, 8'h27, 8'h00, 5'h04, 8'h00, 8'h00, 1'b0},  // R3
        '{1'b1, 8'h04, 8'h00, 5'h04, 8'h04, 8'h00, 1'b0},  // R4
        '{1'b1, 8'h01, 8'h00, 5'h04, 8'h04, 8'h01, 1'b1},  // R4
        '{1'b1, 8'hFB, 8'hFB, 5'h04, 8'h04, 8'h01, 1'b1},  // R6
        '{1'b0, 8'h13, 8'h00, 5'h04, 8'h00, 8'h00, 1'b0},  // R2 single + mode
        '{1'b1, 8'h70, 8'h00, 5'h0E, 8'h00, 8'h00, 1'b0},  // R3
        '{1'b1, 8'h03, 8'h00, 5'h0E, 8'h00, 8'h03, 1'b1},  // R5
        '{1'b1, 8'hA5, 8'hA5, 5'h0E, 8'h00, 8'h03, 1'b1},  // R6
        '{1'b0, 8'h10, 8'h00, 5'h0E, 8'h00, 8'h00, 1'b0},  // R2 no mode word
        '{1'b1, 8'h08, 8'h00, 5'h01, 8'h00, 8'h00, 1'b0},  // R3
        '{1'b1, 8'h02, 8'h00, 5'h01, 8'h02, 8'h00, 1'b1},  // R4
        '{1'b1, 8'h3C, 8'h3C, 5'h01, 8'h02, 8'h00, 1'b1},  // R6
        '{1'b0, 8'h11, 8'h00, 5'h01, 8'h00, 8'h00, 1'b0},  // R2
        '{1'b1, 8'hF8, 8'h00, 5'h1F, 8'h00, 8'h00, 1'b0},  // R3
        '{1'b0, 8'h19, 8'h00, 5'h1F, 8'h00, 8'h00, 1'b0},  // R2 restart mid-sequence
        '{1'b1, 8'h40, 8'h00, 5'h08, 8'h00, 8'h00, 1'b0},  // R3
        '{1'b1, 8'h80, 8'h00, 5'h08, 8'h80, 8'h00, 1'b0},  // R4
        '{1'b1, 8'h1D, 8'h00, 5'h08, 8'h80, 8'h1D, 1'b1}   // R4
    };

    task automatic check(input string req, input string what, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input bit trig, input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_cs_pic  = !trig;
        bus_cs_trig = trig;
        bus_addr    = a;
        bus_wdata   = d;
        bus_wr      = 1'b1;
        @(negedge clk);
        bus_wr      = 1'b0;
        bus_cs_pic  = 1'b0;
        bus_cs_trig = 1'b0;
    endtask

    task automatic bus_read(input bit trig, input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_cs_pic  = !trig;
        bus_cs_trig = trig;
        bus_addr    = a;
        bus_rd      = 1'b1;
        #1 d = bus_rdata;
        bus_rd      = 1'b0;
        bus_cs_pic  = 1'b0;
        bus_cs_trig = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_reset_state();
        check("R1", "mask", 16'(irq_mask), 16'h00FF);
        check("R1", "init_done", 16'(init_done), 16'h0);
        check("R1", "trig", trig_level, 16'h0000);
        check("R1", "vbase", 16'(vec_base), 16'h0);
        check("R1", "cascade", 16'(cascade_cfg), 16'h0);
        check("R1", "mode", 16'(mode_word), 16'h0);
        check("R1", "prio", 16'(lowest_prio), 16'h7);
        check("R1", "smm", 16'(special_mask), 16'h0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        do_reset();
        @(negedge clk);
        check_reset_state();

        // table-driven setup sequences
        for (int i = 0; i < NSTEP; i++) begin
            bus_write(1'b0, STEPS[i].addr, STEPS[i].data);
            check("R6", $sformatf("step%0d mask", i), 16'(irq_mask), 16'(STEPS[i].mask));
            check("R3", $sformatf("step%0d vbase", i), 16'(vec_base), 16'(STEPS[i].vbase));
            check("R4", $sformatf("step%0d cascade", i), 16'(cascade_cfg), 16'(STEPS[i].cas));
            check("R5", $sformatf("step%0d mode", i), 16'(mode_word), 16'(STEPS[i].mode));
            check("R2", $sformatf("step%0d done", i), 16'(init_done), 16'(STEPS[i].done));
        end

        // R3 vector composition
        vec_sel = 3'd3;
        #1 check("R3", "vec_out", 16'(vec_out), 16'h0043);

        // R7 reads
        bus_write(1'b0, 1'b1, 8'h96);
        bus_read(1'b0, 1'b1, rd);
        check("R7", "read mask", 16'(rd), 16'h0096);
        bus_read(1'b0, 1'b0, rd);
        check("R7", "read command port", 16'(rd), 16'h0000);
        @(negedge clk);
        bus_cs_pic = 1'b1; bus_addr = 1'b1;
        #1 check("R7", "rdata without rd", 16'(bus_rdata), 16'h0000);
        bus_cs_pic = 1'b0;

        // R8 trigger register
        bus_write(1'b1, 1'b0, 8'hA5);
        bus_write(1'b1, 1'b1, 8'h3C);
        check("R8", "trig_level", trig_level, 16'h3CA5);
        check("R8", "mask untouched", 16'(irq_mask), 16'h0096);
        bus_read(1'b1, 1'b0, rd);
        check("R8", "read low byte", 16'(rd), 16'h00A5);
        bus_read(1'b1, 1'b1, rd);
        check("R8", "read high byte", 16'(rd), 16'h003C);

        // R11 write with no chip-select
        @(negedge clk);
        bus_addr = 1'b1; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R11", "mask", 16'(irq_mask), 16'h0096);
        check("R11", "trig", trig_level, 16'h3CA5);

        // R9 special mask commands
        bus_write(1'b0, 1'b0, 8'h68);
        check("R9", "smm set", 16'(special_mask), 16'h1);
        bus_write(1'b0, 1'b0, 8'h28);
        check("R9", "smm no-op code", 16'(special_mask), 16'h1);
        bus_write(1'b0, 1'b0, 8'h48);
        check("R9", "smm clear", 16'(special_mask), 16'h0);

        // R10 priority commands
        bus_write(1'b0, 1'b0, 8'hC5);
        check("R10", "prio set", 16'(lowest_prio), 16'h5);
        bus_write(1'b0, 1'b0, 8'h20);
        check("R10", "other code", 16'(lowest_prio), 16'h5);
        check("R10", "mask kept", 16'(irq_mask), 16'h0096);

        // R2 start word clears priority and special mask
        bus_write(1'b0, 1'b0, 8'h68);
        bus_write(1'b0, 1'b0, 8'h11);
        check("R2", "prio after start", 16'(lowest_prio), 16'h7);
        check("R2", "smm after start", 16'(special_mask), 16'h0);
        check("R2", "mask after start", 16'(irq_mask), 16'h0000);

        // R9 / R10 commands ignored while the sequence is pending
        bus_write(1'b0, 1'b0, 8'h68);
        check("R9", "smm ignored mid-sequence", 16'(special_mask), 16'h0);
        bus_write(1'b0, 1'b0, 8'hC2);
        check("R10", "prio ignored mid-sequence", 16'(lowest_prio), 16'h7);

        // R1 reset again
        do_reset();
        @(negedge clk);
        check_reset_state();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule